// File: doc/BRIEF.md
# Synchronous Burst Read Controller

This block is the host-facing read path of a partitioned NOR-style memory. After reset it answers reads asynchronously: a strobed address is looked up and its word is placed on the 16-bit data bus on the next clock, and nothing else moves. A single write to its read configuration register switches it permanently into synchronous burst mode. From then on, every address strobe starts a burst. An internal counter walks through the array, and the first word appears after a programmable number of clocks. Each word is then held for one or two clocks. A WAIT output, with programmable polarity, tells the host whether the bus currently carries valid burst data.

The array behind the controller is a computed, read-only model. Each address maps to a fixed word, so the host side can be exercised without a real storage array. Fixed-length bursts wrap inside an aligned window. Continuous bursts count linearly and run straight across partition boundaries.

Top module: `burst_rd_ctrl`

## Requirements
- R1: After reset, sync_mode is 0, dout is 0 and wait_o is 1 (not busy, since the reset polarity bit is 0).
- R2: In asynchronous mode, dout shows the word of the strobed address one clock edge after the strobe and stays there; the address never advances and wait_o stays 1.
- R3: Any write with cfg_we sets sync_mode to 1 until the next reset and loads the fields: bits 2:0 latency, bit 3 hold (0 = one clock, 1 = two clocks), bit 4 WAIT polarity, bits 6:5 burst length (00 = 4, 01 = 8, 10 = 16, 11 = continuous).
- R4: In synchronous mode, the first word of a burst appears on dout exactly L clock edges after the edge that captured the strobe, where L is the latency field; field values 0 and 1 act as 2.
- R5: In synchronous mode, the controller is busy from the strobe edge until the first-word edge. While busy, wait_o equals the polarity bit; at all other times it equals its inverse.
- R6: Once a burst is running, each word stays on dout for one clock (hold bit 0) or two clocks (hold bit 1), and the address then advances by one step.
- R7: With a burst length of 4, 8 or 16, the address wraps inside the aligned window of that size that holds the start address, and it keeps wrapping until the next strobe.
- R8: With a continuous burst, the address increments linearly. It crosses partition boundaries with no pause or restart and rolls from the top address to 0.
- R9: A strobe during a burst, including during its latency phase, drops that burst and restarts from the new address with a full latency.
- R10: The word stored at address A is the low 16 bits of A times 0x2F1B, XORed with 0x5A3C.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; also paces the burst |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Read configuration register write strobe |
| cfg_wdata | input | 16 | Configuration value |
| addr_vld | input | 1 | Address strobe; starts a read or a burst |
| addr_in | input | AW | Start address |
| dout | output | 16 | Read data |
| wait_o | output | 1 | Data-not-ready indication, polarity per configuration |
| sync_mode | output | 1 | 1 once synchronous burst mode is enabled |

## Verification
The hardest situation to reach is a burst whose address counter leaves its start region. One case is a fixed-length window with a two-clock hold that starts near the end of its window. The other is a continuous burst that runs through a partition edge and then through the top of the address space. The stimulus reaches both by choosing start addresses a few words below a 16-word window edge, below a partition edge at 0x1000, and below 0xFFFF. It also places new strobes both inside the latency phase and inside the data phase, so that the restart case is covered. A behavioural model in the bench predicts dout and wait_o on every clock through all of these steps.

// File: rtl/burst_rd_ctrl.sv
module burst_rd_ctrl #(
  parameter int AW = 16,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_we,
  input  logic [DW-1:0] cfg_wdata,
  input  logic          addr_vld,
  input  logic [AW-1:0] addr_in,
  output logic [DW-1:0] dout,
  output logic          wait_o,
  output logic          sync_mode
);

  localparam logic [31:0] MUL_K = 32'h0000_2F1B;
  localparam logic [DW-1:0] XOR_K = DW'(16'h5A3C);

  logic          sync_q, hold2_q, pol_q, act_q, rdy_q, hcnt_q;
  logic [2:0]    lat_q, lcnt_q;
  logic [1:0]    len_q;
  logic [AW-1:0] addr_q, mask, nxt;
  logic [DW-1:0] dout_q;
  logic          busy;

  function automatic logic [DW-1:0] mem_word(input logic [AW-1:0] a);
    logic [31:0] p;
    p = 32'(a) * MUL_K;
    return p[DW-1:0] ^ XOR_K;
  endfunction

  always_comb begin
    case (len_q)
      2'd0:    mask = AW'(3);
      2'd1:    mask = AW'(7);
      2'd2:    mask = AW'(15);
      default: mask = '1;
    endcase
  end

  assign nxt       = (addr_q & ~mask) | ((addr_q + 1'b1) & mask);
  assign busy      = sync_q & act_q & ~rdy_q;
  assign wait_o    = pol_q ? busy : ~busy;
  assign dout      = dout_q;
  assign sync_mode = sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q  <= 1'b0;
      hold2_q <= 1'b0;
      pol_q   <= 1'b0;
      len_q   <= 2'd0;
      lat_q   <= 3'd2;
      lcnt_q  <= 3'd0;
      act_q   <= 1'b0;
      rdy_q   <= 1'b0;
      hcnt_q  <= 1'b0;
      addr_q  <= '0;
      dout_q  <= '0;
    end else if (cfg_we) begin
      sync_q  <= 1'b1;
      lat_q   <= (cfg_wdata[2:0] < 3'd2) ? 3'd2 : cfg_wdata[2:0];
      hold2_q <= cfg_wdata[3];
      pol_q   <= cfg_wdata[4];
      len_q   <= cfg_wdata[6:5];
      act_q   <= 1'b0;
      rdy_q   <= 1'b0;
    end else if (addr_vld) begin
      addr_q <= addr_in;
      if (sync_q) begin
        act_q  <= 1'b1;
        rdy_q  <= 1'b0;
        lcnt_q <= lat_q;
        hcnt_q <= 1'b0;
      end else begin
        dout_q <= mem_word(addr_in);
      end
    end else if (act_q) begin
      if (!rdy_q) begin
        if (lcnt_q == 3'd1) begin
          rdy_q  <= 1'b1;
          dout_q <= mem_word(addr_q);
          addr_q <= nxt;
          hcnt_q <= 1'b0;
        end else begin
          lcnt_q <= lcnt_q - 3'd1;
        end
      end else if (hold2_q && !hcnt_q) begin
        hcnt_q <= 1'b1;
      end else begin
        dout_q <= mem_word(addr_q);
        addr_q <= nxt;
        hcnt_q <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/burst_rd_ctrl_chk.sv
module burst_rd_ctrl_chk #(
  parameter int AW = 16,
  parameter int DW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cfg_we,
  input logic          addr_vld,
  input logic          sync_mode,
  input logic          wait_o,
  input logic [DW-1:0] dout,
  input logic          pol_q,
  input logic          rdy_q,
  input logic          hold2_q,
  input logic          hcnt_q,
  input logic [1:0]    len_q,
  input logic [AW-1:0] addr_q
);

  AST_ASYNC_NOT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    !sync_mode |-> wait_o); // R2

  AST_CFG_ENABLES_SYNC: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_we |=> sync_mode); // R3

  AST_SYNC_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    sync_mode |=> sync_mode); // R3

  AST_NO_ZERO_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    sync_mode && addr_vld && !cfg_we |=> !rdy_q); // R4

  AST_STROBE_SHOWS_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
    sync_mode && addr_vld && !cfg_we |=> wait_o == pol_q); // R5

  AST_HOLD_TWO: assert property (@(posedge clk) disable iff (!rst_n)
    sync_mode && rdy_q && hold2_q && !hcnt_q && !addr_vld && !cfg_we |=> $stable(dout)); // R6

  AST_WRAP_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
    rdy_q && len_q != 2'b11 && !addr_vld && !cfg_we |=> addr_q[AW-1:4] == $past(addr_q[AW-1:4])); // R7

endmodule

bind burst_rd_ctrl burst_rd_ctrl_chk #(.AW(AW), .DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .addr_vld(addr_vld),
  .sync_mode(sync_mode), .wait_o(wait_o), .dout(dout), .pol_q(pol_q),
  .rdy_q(rdy_q), .hold2_q(hold2_q), .hcnt_q(hcnt_q), .len_q(len_q),
  .addr_q(addr_q)
);

// File: tb/burst_rd_ctrl_test.sv
module burst_rd_ctrl_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [15:0] cfg_wdata = '0;
  logic        addr_vld = 1'b0;
  logic [15:0] addr_in = '0;
  logic [15:0] dout;
  logic        wait_o;
  logic        sync_mode;

  int errors = 0;
  int checks = 0;
  bit chk_on = 1'b0;
  bit done = 1'b0;
  string cur_req = "R1";

  // behavioural reference state
  int m_sync = 0, m_lat = 2, m_hold = 1, m_pol = 0, m_len = 0;
  int m_act = 0, m_rdy = 0, m_rem = 0, m_hc = 0, m_addr = 0, m_dout = 0;

  always #5 clk = ~clk;

  burst_rd_ctrl uut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
    .addr_vld(addr_vld), .addr_in(addr_in), .dout(dout), .wait_o(wait_o),
    .sync_mode(sync_mode)
  );

  function automatic int memw(int a);  // R10
    return ((a * 32'h2F1B) & 32'hFFFF) ^ 32'h5A3C;
  endfunction

  function automatic int nexta(int a, int len);  // R7 R8
    int n, base;
    if (len == 3) return (a + 1) % 65536;
    n = 4 << len;
    base = a - (a % n);
    return base + ((a + 1 - base) % n);
  endfunction

  function automatic logic [15:0] cfgv(int lat, int hold2, int pol, int len);
    return 16'((lat & 7) | ((hold2 & 1) << 3) | ((pol & 1) << 4) | ((len & 3) << 5));
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_sync = 0; m_lat = 2; m_hold = 1; m_pol = 0; m_len = 0;
      m_act = 0; m_rdy = 0; m_rem = 0; m_hc = 0; m_addr = 0; m_dout = 0;
    end else if (cfg_we) begin
      m_sync = 1;
      m_lat  = (cfg_wdata[2:0] < 2) ? 2 : int'(cfg_wdata[2:0]);
      m_hold = cfg_wdata[3] ? 2 : 1;
      m_pol  = int'(cfg_wdata[4]);
      m_len  = int'(cfg_wdata[6:5]);
      m_act = 0; m_rdy = 0;
    end else if (addr_vld) begin
      m_addr = int'(addr_in);
      if (m_sync != 0) begin
        m_act = 1; m_rdy = 0; m_rem = m_lat;
      end else begin
        m_dout = memw(m_addr);
      end
    end else if (m_act != 0) begin
      if (m_rdy == 0) begin
        m_rem = m_rem - 1;
        if (m_rem == 0) begin
          m_rdy = 1;
          m_dout = memw(m_addr); m_addr = nexta(m_addr, m_len); m_hc = 1;
        end
      end else if (m_hc == m_hold) begin
        m_dout = memw(m_addr); m_addr = nexta(m_addr, m_len); m_hc = 1;
      end else begin
        m_hc = m_hc + 1;
      end
    end
  end

  task automatic chk(bit ok, string what, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", cur_req, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (chk_on) begin
      int busy, ew;
      busy = (m_sync != 0 && m_act != 0 && m_rdy == 0) ? 1 : 0;
      ew = (m_pol != 0) ? busy : 1 - busy;
      chk(int'(dout) == m_dout, "dout", int'(dout), m_dout);
      chk(int'(wait_o) == ew, "wait_o", int'(wait_o), ew);
      chk(int'(sync_mode) == m_sync, "sync_mode", int'(sync_mode), m_sync);
    end
  end

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic write_cfg(logic [15:0] v);
    @(negedge clk); cfg_we = 1'b1; cfg_wdata = v;
    @(negedge clk); cfg_we = 1'b0;
  endtask

  task automatic strobe(int a);
    @(negedge clk); addr_vld = 1'b1; addr_in = 16'(a);
    @(negedge clk); addr_vld = 1'b0;
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #2 rst_n = 1'b1;
    @(negedge clk);
    cur_req = "R1";
    chk(sync_mode == 1'b0, "reset sync_mode R1", int'(sync_mode), 0);
    chk(dout == 16'h0, "reset dout R1", int'(dout), 0);
    chk(wait_o == 1'b1, "reset wait_o R1", int'(wait_o), 1);
    chk_on = 1'b1;

    cur_req = "R2 R10";
    strobe(16'h0123); idle(4);
    chk(int'(dout) == memw(16'h0123), "async word R2", int'(dout), memw(16'h0123));
    strobe(16'hBEEF); idle(3);

    cur_req = "R3 R4 R7";
    write_cfg(cfgv(3, 0, 0, 0));
    chk(sync_mode == 1'b1, "sync enabled R3", int'(sync_mode), 1);
    strobe(16'h0046); idle(12);

    cur_req = "R4 R5 R7";
    write_cfg(cfgv(0, 0, 1, 1));
    strobe(16'h0035); idle(14);

    cur_req = "R6 R7";
    write_cfg(cfgv(5, 1, 0, 2));
    strobe(16'h10FD); idle(40);

    cur_req = "R8";
    write_cfg(cfgv(2, 0, 1, 3));
    strobe(16'h0FFC); idle(10);
    strobe(16'hFFFE); idle(6);
    write_cfg(cfgv(4, 1, 0, 3));
    strobe(16'h1FFD); idle(14);

    cur_req = "R9";
    strobe(16'h2000); idle(1);
    strobe(16'h3000); idle(8);
    strobe(16'h4007); idle(3);
    strobe(16'h5000); idle(12);

    cur_req = "R4";
    for (int l = 1; l <= 7; l++) begin
      write_cfg(cfgv(l, 0, l & 1, 0));
      strobe(16'h0100 + l); idle(l + 6);
    end
    chk(sync_mode == 1'b1, "sync stays set R3", int'(sync_mode), 1);

    done = 1'b1;
    summary();
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog %s: actual=hung expected=finished", cur_req);
      summary();
      $finish;
    end
  end
endmodule